// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block starts interrupt and reset entry for a small 8-bit controller core. It holds a register of pending hardware sources, which peripherals set through one-cycle pulses. When the core's global enable is set, no skipped instruction is outstanding, and either a reset request or a pending source is present, the block starts an entry sequence. It saves the return word address on a byte-wide stack, then loads the vector address into the program counter.

The sequence writes one stack byte per clock on a plain byte write port, starting at the current stack pointer and moving one address down per byte. The low byte goes first. In the cycle after the last byte, the block presents the new program counter, the updated stack pointer and a pulse that clears the global enable. In that same cycle it acknowledges the serviced source and drops only that source's pending bit. The width of the saved address (one to three bytes), the number of sources and the vector slot size (1 or 2 words) are parameters fixed at elaboration.

Top module: `irq_entry_seq`

## Requirements
- R1: While `skip_pend` is high, no entry sequence starts; `busy` stays low and no stack write occurs.
- R2: No entry sequence starts while `gie` is low, neither for reset nor for a hardware source.
- R3: A reset request wins over pending hardware sources and uses vector 0, with `rst_ack` high and `ack_src` all zero. Among hardware sources, the set bit with the lowest index wins.
- R4: Source i uses vector i+1. The loaded address `pc_new` equals the vector number times `SLOT_WORDS`.
- R5: The return address `pc_in` is written as `PC_BYTES` bytes, one per clock, low byte first. Byte k goes to address `sp_in - k`.
- R6: In the load cycle, `sp_load` is high and `sp_new` equals `sp_in - PC_BYTES`.
- R7: `gie_clr` is high in exactly the cycle in which `pc_load` is high.
- R8: In the load cycle, `ack_src` is one-hot on the serviced source. Only that bit of `pend_mask` is cleared, and `irq_req` stays high while any other bit remains set.
- R9: `busy` is high from the first stack write through the `pc_load` cycle, which is `PC_BYTES + 1` cycles, and low otherwise.
- R10: A pulse on bit i of `irq_set` sets bit i of `pend_mask` from the next cycle on, whatever the enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_req | input | 1 | Reset entry request (level) |
| irq_set | input | NUM_SRC | One-cycle pulses that set pending bits |
| gie | input | 1 | Global interrupt enable from the core |
| skip_pend | input | 1 | A skip of the next instruction is outstanding |
| pc_in | input | 8*PC_BYTES | Current word program counter (return address) |
| sp_in | input | SP_W | Current stack pointer |
| stk_we | output | 1 | Stack byte write enable |
| stk_addr | output | SP_W | Stack byte address |
| stk_data | output | 8 | Stack byte data |
| pc_load | output | 1 | Load `pc_new` into the program counter |
| pc_new | output | 8*PC_BYTES | Vector address |
| sp_load | output | 1 | Load `sp_new` into the stack pointer |
| sp_new | output | SP_W | Stack pointer after the pushes |
| gie_clr | output | 1 | Clear the global enable |
| rst_ack | output | 1 | Reset request serviced |
| ack_src | output | NUM_SRC | One-hot serviced hardware source |
| pend_mask | output | NUM_SRC | Pending hardware sources |
| irq_req | output | 1 | Any hardware source pending |
| busy | output | 1 | Entry sequence in progress |

## Verification
The assertions check these properties on every cycle: entry is blocked under a skip or a cleared enable, stack addresses step down by one through a burst, and the enable clear coincides with the PC load. They also check that acknowledges are one-hot, that an acknowledged pending bit drops, that the busy window spans the sequence, and that the priority pick grants the lowest request. The bench scenarios show what those properties cannot. These are the exact byte values and their order on the stack, the vector address for each winning source, and the final stack pointer. They also cover reset beating a pending source, and the pending mask draining one source at a time across several patterns.

// File: rtl/ies_pkg.sv
package ies_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PUSH = 2'd1,
      ST_LOAD = 2'd2
   } ies_state_e;
endpackage

// File: rtl/ies_pick.sv
module ies_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0]         req,
   output logic [N-1:0]         grant,
   output logic [$clog2(N)-1:0] idx,
   output logic                 any
);
   localparam int IDX_W = $clog2(N);

   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]  = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = idx | IDX_W'(i);
      end
   end

   // p_lowest_r3: the grant is a requested bit with no request below it
   always_comb begin
      if (!$isunknown(req) && (req != '0)) begin
         p_lowest_r3: assert (((grant & req) != '0) && (((grant - 1'b1) & req) == '0));
      end
   end
endmodule

// File: rtl/ies_pend.sv
module ies_pend #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);
   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr) | set;
   end

   p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr != '0) && ((clr & set) == '0)) |=> ((pend & $past(clr)) == '0));

   p_set_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((pend & $past(set)) == $past(set)));
endmodule

// File: rtl/ies_vec.sv
module ies_vec #(
   parameter int VEC_W      = 4,
   parameter int PC_W       = 16,
   parameter int SLOT_WORDS = 2
) (
   input  logic [VEC_W-1:0] vec,
   output logic [PC_W-1:0]  pc
);
   localparam int SHIFT = $clog2(SLOT_WORDS);

   if (SLOT_WORDS == 1) begin : g_narrow
      assign pc = PC_W'(vec);
   end else if ((1 << SHIFT) == SLOT_WORDS) begin : g_wide
      assign pc = PC_W'(vec) << SHIFT;
   end else begin : g_bad
      $error("SLOT_WORDS must be a power of two");
   end
endmodule

// File: rtl/ies_stack.sv
module ies_stack #(
   parameter int PC_BYTES = 2,
   parameter int SP_W     = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  active,
   input  logic [8*PC_BYTES-1:0] pc,
   input  logic [SP_W-1:0]       sp,
   output logic                  we,
   output logic [SP_W-1:0]       addr,
   output logic [7:0]            data,
   output logic                  last,
   output logic [SP_W-1:0]       sp_cur
);
   localparam int PC_W  = 8 * PC_BYTES;
   localparam int CNT_W = $clog2(PC_BYTES) + 1;

   logic [PC_W-1:0]  shreg;
   logic [CNT_W-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg  <= '0;
         left   <= '0;
         sp_cur <= '0;
      end else if (start) begin
         shreg  <= pc;
         left   <= CNT_W'(PC_BYTES - 1);
         sp_cur <= sp;
      end else if (active) begin
         sp_cur <= sp_cur - 1'b1;
         left   <= left - 1'b1;
         if (PC_BYTES > 1) shreg <= shreg >> 8;
      end
   end

   assign we   = active;
   assign addr = sp_cur;
   assign data = shreg[7:0];
   assign last = active && (left == '0);

   p_sp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && $past(we)) |-> (addr == $past(addr) - 1'b1));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
   parameter int NUM_SRC    = 8,
   parameter int PC_BYTES   = 2,
   parameter int SLOT_WORDS = 2,
   parameter int SP_W       = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reset_req,
   input  logic [NUM_SRC-1:0]    irq_set,
   input  logic                  gie,
   input  logic                  skip_pend,
   input  logic [8*PC_BYTES-1:0] pc_in,
   input  logic [SP_W-1:0]       sp_in,
   output logic                  stk_we,
   output logic [SP_W-1:0]       stk_addr,
   output logic [7:0]            stk_data,
   output logic                  pc_load,
   output logic [8*PC_BYTES-1:0] pc_new,
   output logic                  sp_load,
   output logic [SP_W-1:0]       sp_new,
   output logic                  gie_clr,
   output logic                  rst_ack,
   output logic [NUM_SRC-1:0]    ack_src,
   output logic [NUM_SRC-1:0]    pend_mask,
   output logic                  irq_req,
   output logic                  busy
);
   import ies_pkg::*;

   localparam int PC_W  = 8 * PC_BYTES;
   localparam int IDX_W = $clog2(NUM_SRC);
   localparam int VEC_W = $clog2(NUM_SRC + 1);

   if (PC_BYTES < 1 || PC_BYTES > 3) begin : g_chk_bytes
      $error("PC_BYTES must be 1, 2 or 3");
   end
   if (NUM_SRC < 2) begin : g_chk_src
      $error("NUM_SRC must be at least 2");
   end
   if (SLOT_WORDS < 1 || SLOT_WORDS > 2) begin : g_chk_slot
      $error("SLOT_WORDS must be 1 or 2");
   end
   if (SP_W < 8) begin : g_chk_sp
      $error("SP_W must be at least 8");
   end
   if ((NUM_SRC * SLOT_WORDS) >= (1 << PC_W)) begin : g_chk_fit
      $error("vector table does not fit the PC width");
   end

   ies_state_e         state;
   logic               start, last;
   logic [NUM_SRC-1:0] grant, sel_q, clr;
   logic [IDX_W-1:0]   idx;
   logic               any;
   logic               rst_q;
   logic [VEC_W-1:0]   vec_q;
   logic [SP_W-1:0]    sp_cur;
   logic [PC_W-1:0]    vec_pc;

   ies_pend #(.N(NUM_SRC)) u_pend (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (irq_set),
      .clr  (clr),
      .pend (pend_mask)
   );

   ies_pick #(.N(NUM_SRC)) u_pick (
      .req  (pend_mask),
      .grant(grant),
      .idx  (idx),
      .any  (any)
   );

   ies_stack #(.PC_BYTES(PC_BYTES), .SP_W(SP_W)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .active(state == ST_PUSH),
      .pc    (pc_in),
      .sp    (sp_in),
      .we    (stk_we),
      .addr  (stk_addr),
      .data  (stk_data),
      .last  (last),
      .sp_cur(sp_cur)
   );

   ies_vec #(.VEC_W(VEC_W), .PC_W(PC_W), .SLOT_WORDS(SLOT_WORDS)) u_vec (
      .vec(vec_q),
      .pc (vec_pc)
   );

   assign start = (state == ST_IDLE) && gie && !skip_pend && (reset_req || any);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         rst_q <= 1'b0;
         sel_q <= '0;
         vec_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_PUSH;
               rst_q <= reset_req;
               sel_q <= reset_req ? '0 : grant;
               vec_q <= reset_req ? '0 : VEC_W'(idx) + 1'b1;
            end
            ST_PUSH: if (last) state <= ST_LOAD;
            ST_LOAD: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign pc_load = (state == ST_LOAD);
   assign gie_clr = pc_load;
   assign sp_load = pc_load;
   assign pc_new  = vec_pc;
   assign sp_new  = sp_cur;
   assign rst_ack = pc_load && rst_q;
   assign ack_src = pc_load ? sel_q : '0;
   assign clr     = ack_src;
   assign irq_req = any;
   assign busy    = (state != ST_IDLE);

   p_skip_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && skip_pend) |=> !busy);

   p_gie_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !gie) |=> !busy);

   p_reset_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ack |-> (pc_new == '0 && ack_src == '0));

   p_hw_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && !rst_ack) |-> (pc_new != '0 && $countones(ack_src) == 1));

   p_load_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> (gie_clr && sp_load && !stk_we));

   p_one_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_src));

   p_busy_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> stk_we);

   p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(pc_load));
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
   localparam int NS = 8;
   localparam int PB = 2;
   localparam int SW = 2;
   localparam int SPW = 16;

   logic clk = 0, rst_n = 0;
   logic reset_req = 0, gie = 0, skip_pend = 0;
   logic [NS-1:0] irq_set = '0;
   logic [8*PB-1:0] pc_in = '0;
   logic [SPW-1:0] sp_in = '0;
   logic stk_we, pc_load, sp_load, gie_clr, rst_ack, irq_req, busy;
   logic [SPW-1:0] stk_addr, sp_new;
   logic [7:0] stk_data;
   logic [8*PB-1:0] pc_new;
   logic [NS-1:0] ack_src, pend_mask;

   int checks = 0, fails = 0;
   logic [31:0] qa[$], qd[$], qpc[$], qsp[$], qack[$], qrst[$];

   always #4 clk = ~clk;

   irq_entry_seq #(.NUM_SRC(NS), .PC_BYTES(PB), .SLOT_WORDS(SW), .SP_W(SPW)) dut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops expected stack bytes and load results
   always @(negedge clk) if (rst_n) begin
      if (stk_we) begin
         if (qa.size() == 0) chk(0, "R5", "unexpected stack write", stk_addr, 0);
         else begin
            logic [31:0] a, d;
            a = qa.pop_front(); d = qd.pop_front();
            chk(stk_addr == a[SPW-1:0], "R5", "stack address", stk_addr, a);
            chk(stk_data == d[7:0], "R5", "stack byte", stk_data, d);
         end
      end
      if (pc_load) begin
         if (qpc.size() == 0) chk(0, "R4", "unexpected load", pc_new, 0);
         else begin
            logic [31:0] p, s, k, r;
            p = qpc.pop_front(); s = qsp.pop_front();
            k = qack.pop_front(); r = qrst.pop_front();
            chk(pc_new == p[8*PB-1:0], "R4", "vector address", pc_new, p);
            chk(sp_load && sp_new == s[SPW-1:0], "R6", "final sp", sp_new, s);
            chk(gie_clr, "R7", "gie clear with load", gie_clr, 1);
            chk(ack_src == k[NS-1:0], "R8", "ack source", ack_src, k);
            chk(rst_ack == r[0], "R3", "reset ack", rst_ack, r);
         end
      end
   end

   // driver: queue expectations, enable, wait for load
   task automatic entry(input int vec, input logic [NS-1:0] ack, input bit rst,
                        input logic [8*PB-1:0] pc, input logic [SPW-1:0] sp);
      int bc = 0;
      pc_in = pc; sp_in = sp;
      for (int k = 0; k < PB; k++) begin
         qa.push_back(32'(sp - SPW'(k)));
         qd.push_back(32'((pc >> (8 * k)) & 8'hff));
      end
      qpc.push_back(32'(vec * SW));
      qsp.push_back(32'(sp - SPW'(PB)));
      qack.push_back(32'(ack));
      qrst.push_back(32'(rst));
      gie = 1;
      do begin
         @(negedge clk);
         if (busy) bc++;
      end while (!pc_load);
      gie = 0;
      if (rst) reset_req = 0;
      chk(bc == PB + 1, "R9", "busy length", bc, PB + 1);
      @(negedge clk);
      chk(!busy && !stk_we, "R9", "busy drops after load", busy, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "WDOG", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && !stk_we && !pc_load && pend_mask == 0 && !irq_req, "R9",
          "reset state", {busy, pend_mask}, 0);

      // R10: set pending with enable low
      irq_set = 8'hA4; @(negedge clk); irq_set = '0;
      chk(pend_mask == 8'hA4 && irq_req, "R10", "pending set", pend_mask, 8'hA4);
      repeat (4) @(negedge clk);
      chk(!busy && pend_mask == 8'hA4, "R2", "no entry with gie low", busy, 0);

      // R1: skip pending blocks entry
      skip_pend = 1; gie = 1;
      repeat (5) @(negedge clk);
      chk(!busy && pend_mask == 8'hA4, "R1", "no entry under skip", busy, 0);
      gie = 0; skip_pend = 0;
      @(negedge clk);

      // lowest source (2) wins: vector 3
      entry(3, 8'h04, 0, 16'h1234, 16'h08FF);
      chk(pend_mask == 8'hA0 && irq_req, "R8", "only bit 2 cleared", pend_mask, 8'hA0);
      entry(6, 8'h20, 0, 16'hBEEF, 16'h08FD);
      chk(pend_mask == 8'h80 && irq_req, "R8", "only bit 5 cleared", pend_mask, 8'h80);
      entry(8, 8'h80, 0, 16'h00C1, 16'h0400);
      chk(pend_mask == 8'h00 && !irq_req, "R8", "request drops", pend_mask, 0);

      // R2 for reset too
      reset_req = 1;
      repeat (4) @(negedge clk);
      chk(!busy, "R2", "reset waits for gie", busy, 0);

      // R3: reset wins over pending source 0
      irq_set = 8'h01; @(negedge clk); irq_set = '0;
      entry(0, 8'h00, 1, 16'h5A7E, 16'h0100);
      chk(pend_mask == 8'h01, "R3", "source kept after reset entry", pend_mask, 8'h01);
      entry(1, 8'h01, 0, 16'hFF00, 16'h0001);
      chk(pend_mask == 8'h00, "R4", "source 0 drained", pend_mask, 0);

      repeat (3) @(negedge clk);
      chk(qa.size() == 0 && qpc.size() == 0, "R5", "all expected items seen",
          qa.size() + qpc.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule